// File: doc/BRIEF.md
# Flash ECC Fault Reporting Controller

This block sits between an external flash ECC decoder and the processor. It holds a configuration register, an error-interrupt enable register, a fault status register and a fault-capture register. On each array read the decoder reports single-bit and double-bit faults. The block then raises status flags, records the address of genuine faults, and drives a command-complete interrupt and a fault interrupt toward the CPU.

Software can inject faults to test its handlers. A force bit makes every array read set the chosen status flag, and the capture register is left untouched unless a real fault is present. Real single-bit faults can also be suppressed entirely. The status flags clear when software writes 1 to them. A captured address stays frozen until software acknowledges the flag.

Top module: `flash_ecc_fault_ctl`

## Requirements
- R1: After reset every register reads 0, and both `cc_irq` and `fault_irq` are low.
- R2: Configuration register (offset 0) has these fields: bit 7 is the command-complete interrupt enable, bit 4 ignores single faults, bit 1 forces double faults, and bit 0 forces single faults. The error enable register (offset 1) has bit 1 as the double-fault interrupt enable and bit 0 as the single-fault interrupt enable. All other bits of both registers read 0 and ignore writes.
- R3: `cc_irq` is high exactly when `cmd_done` is high and configuration bit 7 is 1.
- R4: Status register (offset 2) has bit 0 as the single-fault flag and bit 1 as the double-fault flag. A cycle with `rd_strobe` high sets bit 1 when `dbl_fault` is high or the force-double bit is set. The same cycle sets bit 0 when the force-single bit is set, or when `sgl_fault` is high and ignore-single is 0. Fault inputs have no effect while `rd_strobe` is low.
- R5: With ignore-single set, a real single fault sets no flag and captures nothing. A forced single fault still sets bit 0.
- R6: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. A fault that sets the same flag in the same cycle wins, and the flag stays 1.
- R7: The capture register is updated only by real faults, never by force alone. A real double fault captures when the double flag was clear. A reported real single fault without a double fault captures when both flags were clear. The address is read little-endian from offset 4 upward, and offset 3 bit 0 gives the captured type (1 = double).
- R8: While the flag that governs capture is set, later faults do not change the captured address or type.
- R9: `fault_irq` is high exactly when some status bit and the matching error-enable bit are both 1.
- R10: Force bits stay set across any number of array reads until software writes 0 to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register offset for read and write |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| rd_strobe | input | 1 | One-cycle pulse marking an array read |
| sgl_fault | input | 1 | Decoder reports a single-bit fault |
| dbl_fault | input | 1 | Decoder reports a double-bit fault |
| rd_addr | input | ADDR_W | Address of the array read |
| cmd_done | input | 1 | Command-complete flag |
| cc_irq | output | 1 | Command-complete interrupt |
| fault_irq | output | 1 | ECC fault interrupt |

## Verification
The hardest cases to reach involve the capture register while a flag is already set, which needs a chain of faults with selective acknowledges between them. One example is a single fault that arrives while only the double flag is pending. Another is an acknowledge write that lands in the same cycle as a new fault. The bench drives register writes and read strobes in one cycle to create the clash. Before that, it sweeps every combination of force bits, ignore bit and decoder fault pair from cleared flags, with the expected flags and capture computed from the rules above.

// File: rtl/fecc_pkg.sv
package fecc_pkg;
  localparam logic [2:0] OFS_CFG    = 3'd0;
  localparam logic [2:0] OFS_ERRCFG = 3'd1;
  localparam logic [2:0] OFS_STAT   = 3'd2;
  localparam logic [2:0] OFS_CTYPE  = 3'd3;
  localparam logic [2:0] OFS_CADDR  = 3'd4;

  typedef struct packed {
    logic cc_en;
    logic ign_sgl;
    logic frc_dbl;
    logic frc_sgl;
  } cfg_t;
endpackage

// File: rtl/flash_fault_cfg_regs.sv
module flash_fault_cfg_regs
  import fecc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output cfg_t       cfg,
  output logic [1:0] err_en
);
  cfg_t       cfg_q, cfg_d;
  logic [1:0] en_q, en_d;
  logic       cfg_ld, en_ld;

  always_comb begin
    cfg_ld = wr_en && (wr_addr == OFS_CFG);
    en_ld  = wr_en && (wr_addr == OFS_ERRCFG);
    cfg_d  = '{cc_en: wr_data[7], ign_sgl: wr_data[4],
               frc_dbl: wr_data[1], frc_sgl: wr_data[0]};
    en_d   = wr_data[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      en_q  <= '0;
    end else begin
      if (cfg_ld) cfg_q <= cfg_d;
      if (en_ld)  en_q  <= en_d;
    end
  end

  assign cfg    = cfg_q;
  assign err_en = en_q;

  // R10
  force_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.frc_sgl && !cfg_ld) |=> cfg_q.frc_sgl);
endmodule

// File: rtl/flash_fault_capture.sv
module flash_fault_capture
  import fecc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_t              cfg,
  input  logic              rd_strobe,
  input  logic              sgl_fault,
  input  logic              dbl_fault,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              clr_en,
  input  logic [1:0]        clr_mask,
  output logic [1:0]        flags,
  output logic [ADDR_W-1:0] cap_addr,
  output logic              cap_dbl
);
  logic [1:0]        flg_q, flg_d, set_v;
  logic [ADDR_W-1:0] cap_q, cap_d;
  logic              typ_q, typ_d, cap_ld;
  logic              real_s, real_d;

  always_comb begin
    real_d   = rd_strobe && dbl_fault;
    real_s   = rd_strobe && sgl_fault && !cfg.ign_sgl;
    set_v[1] = real_d || (rd_strobe && cfg.frc_dbl);
    set_v[0] = real_s || (rd_strobe && cfg.frc_sgl);
    flg_d    = (flg_q & ~(clr_en ? clr_mask : 2'b00)) | set_v;
    cap_ld   = 1'b0;
    cap_d    = cap_q;
    typ_d    = typ_q;
    if (real_d && !flg_q[1]) begin
      cap_ld = 1'b1;
      cap_d  = rd_addr;
      typ_d  = 1'b1;
    end else if (real_s && !real_d && (flg_q == 2'b00)) begin
      cap_ld = 1'b1;
      cap_d  = rd_addr;
      typ_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
      cap_q <= '0;
      typ_q <= 1'b0;
    end else begin
      flg_q <= flg_d;
      if (cap_ld) begin
        cap_q <= cap_d;
        typ_q <= typ_d;
      end
    end
  end

  assign flags    = flg_q;
  assign cap_addr = cap_q;
  assign cap_dbl  = typ_q;

  // R4
  frc_dbl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && cfg.frc_dbl) |=> flg_q[1]);
  // R6
  w1c_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flg_q[0]) |-> $past(clr_en && clr_mask[0]));
  // R8
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flg_q[1] |=> ($stable(cap_q) && $stable(typ_q)));
  // R7
  no_force_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sgl_fault && !dbl_fault) |=> $stable(cap_q));
endmodule

// File: rtl/flash_ecc_fault_ctl.sv
module flash_ecc_fault_ctl
  import fecc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        reg_addr,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              rd_strobe,
  input  logic              sgl_fault,
  input  logic              dbl_fault,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              cmd_done,
  output logic              cc_irq,
  output logic              fault_irq
);
  localparam int CAP_BYTES = (ADDR_W + 7) / 8;
  localparam int PAD_W     = CAP_BYTES * 8;

  logic [1:0]        rst_sync;
  logic              rst_ni;
  cfg_t              cfg;
  logic [1:0]        err_en, flags;
  logic [ADDR_W-1:0] cap_addr;
  logic              cap_dbl;
  logic [PAD_W-1:0]  cap_pad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  flash_fault_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_ni), .wr_en(reg_we), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .cfg(cfg), .err_en(err_en)
  );

  flash_fault_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst_n(rst_ni), .cfg(cfg), .rd_strobe(rd_strobe),
    .sgl_fault(sgl_fault), .dbl_fault(dbl_fault), .rd_addr(rd_addr),
    .clr_en(reg_we && (reg_addr == OFS_STAT)), .clr_mask(reg_wdata[1:0]),
    .flags(flags), .cap_addr(cap_addr), .cap_dbl(cap_dbl)
  );

  always_comb begin
    cap_pad   = '0;
    cap_pad[ADDR_W-1:0] = cap_addr;
    reg_rdata = 8'h00;
    case (reg_addr)
      OFS_CFG:    reg_rdata = {cfg.cc_en, 2'b00, cfg.ign_sgl, 2'b00,
                               cfg.frc_dbl, cfg.frc_sgl};
      OFS_ERRCFG: reg_rdata = {6'b0, err_en};
      OFS_STAT:   reg_rdata = {6'b0, flags};
      OFS_CTYPE:  reg_rdata = {7'b0, cap_dbl};
      default: begin
        for (int k = 0; k < CAP_BYTES; k++)
          if (int'(reg_addr) - int'(OFS_CADDR) == k)
            reg_rdata = cap_pad[k*8 +: 8];
      end
    endcase
  end

  assign cc_irq    = cmd_done && cfg.cc_en;
  assign fault_irq = |(flags & err_en);

  // R3
  cc_gate_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !cfg.cc_en |-> !cc_irq);
  // R9
  fault_gate_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (flags == 2'b00) |-> !fault_irq);
endmodule

// File: tb/flash_ecc_fault_ctl_tb.sv
module flash_ecc_fault_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        rd_strobe = 1'b0, sgl_fault = 1'b0, dbl_fault = 1'b0;
  logic [15:0] rd_addr = '0;
  logic        cmd_done = 1'b0;
  logic        cc_irq, fault_irq;
  int          n_chk = 0, n_bad = 0;
  logic [15:0] e_addr = '0;
  logic        e_typ = 1'b0;

  always #10 clk = ~clk;

  flash_ecc_fault_ctl #(.ADDR_W(16)) dut_i (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic strobe(input logic s, input logic d, input logic [15:0] a);
    @(negedge clk); rd_strobe = 1'b1; sgl_fault = s; dbl_fault = d; rd_addr = a;
    @(negedge clk); rd_strobe = 1'b0; sgl_fault = 1'b0; dbl_fault = 1'b0;
  endtask

  task automatic chk_cap(input string req);
    logic [7:0] lo, hi, t;
    rd(3'd4, lo); rd(3'd5, hi); rd(3'd3, t);
    chk(req, {hi, lo}, e_addr);
    chk(req, {15'b0, t[0]}, {15'b0, e_typ});
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin rd(3'(a), v); chk("R1", {8'h0, v}, 16'h0); end
    cmd_done = 1'b1; #1 chk("R1", {15'b0, cc_irq}, 16'h0);
    chk("R1", {15'b0, fault_irq}, 16'h0);

    // R2 writable masks
    wr(3'd0, 8'hFF); rd(3'd0, v); chk("R2", {8'h0, v}, 16'h0093);
    wr(3'd1, 8'hFF); rd(3'd1, v); chk("R2", {8'h0, v}, 16'h0003);
    wr(3'd0, 8'h6C); rd(3'd0, v); chk("R2", {8'h0, v}, 16'h0000);
    wr(3'd1, 8'h00);

    // R3 sweep
    for (int i = 0; i < 4; i++) begin
      wr(3'd0, i[0] ? 8'h80 : 8'h00);
      @(negedge clk); cmd_done = i[1]; #1;
      chk("R3", {15'b0, cc_irq}, {15'b0, i[0] & i[1]});
    end
    cmd_done = 1'b0;

    // R4 R5 R7 exhaustive sweep from cleared flags
    for (int i = 0; i < 32; i++) begin
      logic fs, fd, ig, s, d, es, ed;
      {ig, fd, fs, d, s} = 5'(i);
      wr(3'd0, {3'b0, ig, 2'b0, fd, fs});
      wr(3'd2, 8'h03);
      strobe(s, d, 16'h1000 + 16'(i * 37));
      es = fs | (s & ~ig); ed = fd | d;
      if (d) begin e_addr = 16'h1000 + 16'(i * 37); e_typ = 1'b1; end
      else if (s & ~ig) begin e_addr = 16'h1000 + 16'(i * 37); e_typ = 1'b0; end
      rd(3'd2, v); chk("R4/R5", {8'h0, v}, {14'b0, ed, es});
      chk_cap("R7");
    end

    // R4 fault inputs without strobe
    wr(3'd0, 8'h00); wr(3'd2, 8'h03);
    @(negedge clk); sgl_fault = 1'b1; dbl_fault = 1'b1; rd_addr = 16'hDEAD;
    @(negedge clk); sgl_fault = 1'b0; dbl_fault = 1'b0;
    rd(3'd2, v); chk("R4", {8'h0, v}, 16'h0);
    chk_cap("R4");

    // R8 hold
    strobe(1'b0, 1'b1, 16'hA001); e_addr = 16'hA001; e_typ = 1'b1; chk_cap("R8");
    strobe(1'b0, 1'b1, 16'hA002); chk_cap("R8");
    strobe(1'b1, 1'b0, 16'hA003); chk_cap("R8");
    rd(3'd2, v); chk("R8", {8'h0, v}, 16'h0003);
    wr(3'd2, 8'h02); rd(3'd2, v); chk("R6", {8'h0, v}, 16'h0001);
    strobe(1'b1, 1'b0, 16'hA004); chk_cap("R8");
    wr(3'd2, 8'h01); rd(3'd2, v); chk("R6", {8'h0, v}, 16'h0000);
    strobe(1'b1, 1'b0, 16'hA005); e_addr = 16'hA005; e_typ = 1'b0; chk_cap("R7");

    // R6 set wins over clear in the same cycle
    @(negedge clk); reg_addr = 3'd2; reg_wdata = 8'h01; reg_we = 1'b1;
    rd_strobe = 1'b1; sgl_fault = 1'b1; rd_addr = 16'hA006;
    @(negedge clk); reg_we = 1'b0; rd_strobe = 1'b0; sgl_fault = 1'b0;
    rd(3'd2, v); chk("R6", {8'h0, v}, 16'h0001);
    chk_cap("R8");
    wr(3'd2, 8'h00); rd(3'd2, v); chk("R6", {8'h0, v}, 16'h0001);
    wr(3'd2, 8'h01); rd(3'd2, v); chk("R6", {8'h0, v}, 16'h0000);

    // R10 force persistence
    wr(3'd0, 8'h01);
    for (int k = 0; k < 3; k++) begin
      strobe(1'b0, 1'b0, 16'(k));
      rd(3'd2, v); chk("R10", {8'h0, v}, 16'h0001);
      wr(3'd2, 8'h03);
      rd(3'd0, v); chk("R10", {8'h0, v}, 16'h0001);
    end
    chk_cap("R10");

    // R9 sweep
    for (int i = 0; i < 16; i++) begin
      logic [1:0] f, e;
      {e, f} = 4'(i);
      wr(3'd2, 8'h03);
      wr(3'd0, {6'b0, f});
      strobe(1'b0, 1'b0, 16'h0);
      wr(3'd0, 8'h00);
      wr(3'd1, {6'b0, e});
      #1 chk("R9", {15'b0, fault_irq}, {15'b0, |(f & e)});
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule